// File: doc/BRIEF.md
# FIFO UART Transmit Status and Interrupt Logic

This block watches the transmit side of a 16550-compatible UART that has its FIFOs switched on. It produces the holding-register-empty interrupt with its identification code. It also produces four status bits: receive data ready, transmit FIFO empty, transmitter fully idle, and receive error present. The serializer, the FIFOs themselves, the receive data path and the host bus all sit outside. The block sees them only through the FIFO occupancy counts, a shift-register busy flag, a 16x baud tick and two one-cycle strobes. One strobe marks a write to the holding register. The other marks a read of the interrupt-identification register.

Suppose the transmit FIFO drains after holding only a single byte at a time since the last empty event. In that case the empty indication, and the interrupt it causes, are held back. The hold lasts one character time less the final stop bit, so that software does not refill the FIFO one byte per interrupt while the line is still busy. If the FIFO held two or more bytes together in that period, empty is reported at once.

Flipping the FIFO-enable control raises the interrupt immediately. Clearing the interrupt enable gives polled operation: the status bits keep working and the interrupt line stays low. Every output is registered.

Top module: `uart_tx_status`

## Requirements
- R1: In reset and right after it, tx_empty and tx_idle read 1, irq reads 0, irq_code reads 4'h1, and rx_ready and rx_error read 0.
- R2: With fifo_en=1, a nonzero tx_level on one clock edge makes tx_empty 0 after that edge.
- R3: With fifo_en=1, suppose tx_level was 2 or more on some edge since tx_empty last rose. Then the first edge that sees tx_level=0 sets tx_empty after that edge.
- R4: With fifo_en=1 and no such history, the first edge that sees tx_level=0 starts a hold of D baud ticks. tx_empty rises after the edge that carries the D-th tick. D = 16*(6 + wlen + par_en + stop2), where wlen=0..3 selects 5..8 data bits and stop2=1 selects two stop bits. Any nonzero level cancels the hold.
- R5: With fifo_en=0, tx_empty equals (tx_level==0) as seen on the previous edge, with no hold.
- R6: A rise of tx_empty makes the interrupt pending in the same cycle. irq = pending AND tx_irq_en. irq_code is 4'h2 while irq=1 and 4'h1 otherwise.
- R7: A hold_wr or id_rd pulse clears the pending interrupt, unless a set event happens on the same edge.
- R8: A change of fifo_en between two edges makes the interrupt pending after the second edge.
- R9: A rise of tx_irq_en while tx_empty=1 makes the interrupt pending at once.
- R10: tx_idle is 1 only when tx_empty is 1 and tsr_busy was 0 on the same edge.
- R11: rx_ready shows rx_level != 0 and rx_error shows rx_err_cnt != 0, one edge later, whatever the interrupt enables are.
- R12: With tx_irq_en=0 (polled mode), irq stays 0 while tx_empty and the other status bits still update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | FIFO mode enable control bit |
| tx_irq_en | input | 1 | Transmit-empty interrupt enable |
| hold_wr | input | 1 | One-cycle strobe: holding register written |
| id_rd | input | 1 | One-cycle strobe: interrupt-identification register read |
| tx_level | input | LVL_W | Transmit FIFO occupancy, 0..DEPTH |
| tsr_busy | input | 1 | Transmit shift register still holds bits |
| baud_tick | input | 1 | 16x baud rate enable pulse |
| wlen | input | 2 | Data bits minus 5 |
| par_en | input | 1 | Parity bit present |
| stop2 | input | 1 | Two stop bits |
| rx_level | input | LVL_W | Receive FIFO occupancy |
| rx_err_cnt | input | LVL_W | Count of erroneous bytes in the receive FIFO |
| irq | output | 1 | Transmit interrupt request |
| irq_code | output | 4 | Interrupt identification: 4'h2 transmit empty, 4'h1 none |
| rx_ready | output | 1 | Receive FIFO holds data |
| tx_empty | output | 1 | Transmit FIFO reported empty |
| tx_idle | output | 1 | Transmit FIFO and shift register both empty |
| rx_error | output | 1 | Receive FIFO holds at least one errored byte |

## Verification
The hardest state to reach is a hold that runs to completion and then, right after it, a second drain that must be held again. Reaching it takes a single-byte burst and a quiet line for over a hundred ticks. It also needs the two-byte history to have been cleared by the previous empty event. Directed bursts of one and two bytes, counted to the exact expiry edge for two frame formats, reach this state. A random phase then alternates bursts of one to three bytes with idle gaps of random length at a random tick rate. Across that phase a bench reference model follows the hold, the history flag and the pending interrupt edge by edge.

// File: rtl/uart_txs_pkg.sv
package uart_txs_pkg;

  localparam logic [3:0] CODE_TX_EMPTY = 4'h2;
  localparam logic [3:0] CODE_NONE     = 4'h1;

  // Hold length in baud ticks: start bit, data bits, optional parity and
  // an optional second stop bit; the last stop bit is left out.
  function automatic int unsigned hold_ticks(input int unsigned ovs,
                                             input logic [1:0] wlen,
                                             input logic par_en,
                                             input logic stop2);
    return ovs * (6 + int'(wlen) + int'(par_en) + int'(stop2));
  endfunction

endpackage

// File: rtl/txs_empty_tracker.sv
module txs_empty_tracker
  import uart_txs_pkg::*;
#(
  parameter int LVL_W = 5,
  parameter int CNT_W = 8,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_en,
  input  logic [LVL_W-1:0] tx_level,
  input  logic             baud_tick,
  input  logic [1:0]       wlen,
  input  logic             par_en,
  input  logic             stop2,
  output logic             empty_q,
  output logic             empty_d
);

  logic             wait_q, wait_d;
  logic             multi_q, multi_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             lvl_zero, lvl_two;
  logic [CNT_W-1:0] hold_len;

  assign lvl_zero = (tx_level == '0);
  assign lvl_two  = (tx_level >= LVL_W'(2));
  assign hold_len = CNT_W'(hold_ticks(OVS, wlen, par_en, stop2));

  always_comb begin
    empty_d = empty_q;
    wait_d  = wait_q;
    cnt_d   = cnt_q;
    if (!fifo_en) begin
      empty_d = lvl_zero;
      wait_d  = 1'b0;
      cnt_d   = '0;
    end else if (!lvl_zero) begin
      empty_d = 1'b0;
      wait_d  = 1'b0;
      cnt_d   = '0;
    end else if (!empty_q) begin
      if (!wait_q) begin
        if (multi_q) begin
          empty_d = 1'b1;
        end else begin
          wait_d = 1'b1;
          cnt_d  = '0;
        end
      end else if (baud_tick) begin
        if (cnt_q >= hold_len - CNT_W'(1)) begin
          empty_d = 1'b1;
          wait_d  = 1'b0;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
    end
  end

  always_comb begin
    multi_d = multi_q;
    if (empty_d && !empty_q) multi_d = 1'b0;
    else if (lvl_two)        multi_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      empty_q <= 1'b1;
      wait_q  <= 1'b0;
      cnt_q   <= '0;
      multi_q <= 1'b0;
    end else begin
      empty_q <= empty_d;
      wait_q  <= wait_d;
      cnt_q   <= cnt_d;
      multi_q <= multi_d;
    end
  end

  // R2
  level_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (fifo_en && tx_level != '0) |=> !empty_q);
  // R3
  multi_fast_chk: assert property (@(posedge clk) disable iff (rst)
    (fifo_en && lvl_zero && multi_q && !empty_q) |=> empty_q);
  // R4
  hold_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (fifo_en && lvl_zero && wait_q && !baud_tick && !empty_q) |=> !empty_q);
  // R5
  legacy_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !fifo_en |=> (empty_q == $past(tx_level == '0)));

endmodule

// File: rtl/txs_irq_ctrl.sv
module txs_irq_ctrl
  import uart_txs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       fifo_en,
  input  logic       tx_irq_en,
  input  logic       hold_wr,
  input  logic       id_rd,
  input  logic       empty_q,
  input  logic       empty_d,
  output logic       irq_q,
  output logic [3:0] code_q
);

  logic pend_q, pend_d;
  logic fen_q, ien_q;
  logic set_ev, clr_ev;

  assign set_ev = (empty_d && !empty_q)
                || (fifo_en != fen_q)
                || (tx_irq_en && !ien_q && empty_q);
  assign clr_ev = hold_wr || id_rd;

  always_comb begin
    pend_d = pend_q;
    if (set_ev)      pend_d = 1'b1;
    else if (clr_ev) pend_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      fen_q  <= fifo_en;
      ien_q  <= tx_irq_en;
      irq_q  <= 1'b0;
      code_q <= CODE_NONE;
    end else begin
      pend_q <= pend_d;
      fen_q  <= fifo_en;
      ien_q  <= tx_irq_en;
      irq_q  <= pend_d && tx_irq_en;
      code_q <= (pend_d && tx_irq_en) ? CODE_TX_EMPTY : CODE_NONE;
    end
  end

  // R6
  empty_rise_pend_chk: assert property (@(posedge clk) disable iff (rst)
    (empty_d && !empty_q) |=> pend_q);
  // R8
  fen_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (fifo_en != fen_q) |=> pend_q);
  // R12
  masked_irq_chk: assert property (@(posedge clk) disable iff (rst)
    !tx_irq_en |=> !irq_q);

endmodule

// File: rtl/txs_line_status.sv
module txs_line_status #(
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             empty_d,
  input  logic             tsr_busy,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] rx_err_cnt,
  output logic             ready_q,
  output logic             idle_q,
  output logic             err_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b0;
      idle_q  <= 1'b1;
      err_q   <= 1'b0;
    end else begin
      ready_q <= (rx_level != '0);
      idle_q  <= empty_d && !tsr_busy;
      err_q   <= (rx_err_cnt != '0);
    end
  end

  // R10
  busy_not_idle_chk: assert property (@(posedge clk) disable iff (rst)
    tsr_busy |=> !idle_q);
  // R11
  rx_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_level != '0) |=> ready_q);

endmodule

// File: rtl/uart_tx_status.sv
module uart_tx_status
  import uart_txs_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int OVS   = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         fifo_en,
  input  logic                         tx_irq_en,
  input  logic                         hold_wr,
  input  logic                         id_rd,
  input  logic [$clog2(DEPTH+1)-1:0]   tx_level,
  input  logic                         tsr_busy,
  input  logic                         baud_tick,
  input  logic [1:0]                   wlen,
  input  logic                         par_en,
  input  logic                         stop2,
  input  logic [$clog2(DEPTH+1)-1:0]   rx_level,
  input  logic [$clog2(DEPTH+1)-1:0]   rx_err_cnt,
  output logic                         irq,
  output logic [3:0]                   irq_code,
  output logic                         rx_ready,
  output logic                         tx_empty,
  output logic                         tx_idle,
  output logic                         rx_error
);

  localparam int LVL_W     = $clog2(DEPTH + 1);
  localparam int MAX_TICKS = OVS * 11;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  logic empty_q, empty_d;

  txs_empty_tracker #(.LVL_W(LVL_W), .CNT_W(CNT_W), .OVS(OVS)) u_track (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .tx_level(tx_level),
    .baud_tick(baud_tick), .wlen(wlen), .par_en(par_en), .stop2(stop2),
    .empty_q(empty_q), .empty_d(empty_d)
  );

  txs_irq_ctrl u_irq (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .tx_irq_en(tx_irq_en),
    .hold_wr(hold_wr), .id_rd(id_rd), .empty_q(empty_q), .empty_d(empty_d),
    .irq_q(irq), .code_q(irq_code)
  );

  txs_line_status #(.LVL_W(LVL_W)) u_stat (
    .clk(clk), .rst(rst), .empty_d(empty_d), .tsr_busy(tsr_busy),
    .rx_level(rx_level), .rx_err_cnt(rx_err_cnt),
    .ready_q(rx_ready), .idle_q(tx_idle), .err_q(rx_error)
  );

  assign tx_empty = empty_q;

endmodule

// File: tb/tb_uart_tx_status.sv
`timescale 1ns/100ps
module tb_uart_tx_status;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fifo_en = 1'b1, tx_irq_en = 1'b1, hold_wr = 1'b0, id_rd = 1'b0;
  logic [4:0] tx_level = '0, rx_level = '0, rx_err_cnt = '0;
  logic tsr_busy = 1'b0, baud_tick = 1'b1, par_en = 1'b0, stop2 = 1'b0;
  logic [1:0] wlen = 2'd3;
  logic irq, rx_ready, tx_empty, tx_idle, rx_error;
  logic [3:0] irq_code;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  uart_tx_status dut (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .tx_irq_en(tx_irq_en),
    .hold_wr(hold_wr), .id_rd(id_rd), .tx_level(tx_level),
    .tsr_busy(tsr_busy), .baud_tick(baud_tick), .wlen(wlen),
    .par_en(par_en), .stop2(stop2), .rx_level(rx_level),
    .rx_err_cnt(rx_err_cnt), .irq(irq), .irq_code(irq_code),
    .rx_ready(rx_ready), .tx_empty(tx_empty), .tx_idle(tx_idle),
    .rx_error(rx_error)
  );

  function automatic int hold_len(input logic [1:0] w, input logic p,
                                  input logic s);
    return 16 * (6 + int'(w) + int'(p) + int'(s));
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Reference model, advanced on each rising edge from the driven inputs.
  logic m_empty, m_wait, m_multi, m_pend, m_fen, m_ien;
  logic m_irq, m_idle, m_rdy, m_err;
  logic [3:0] m_code;
  int m_cnt;

  always @(posedge clk) begin
    logic n_empty, n_pend;
    if (rst) begin
      m_empty = 1; m_wait = 0; m_cnt = 0; m_multi = 0; m_pend = 0;
      m_fen = fifo_en; m_ien = tx_irq_en; m_irq = 0; m_code = 4'h1;
      m_idle = 1; m_rdy = 0; m_err = 0;
    end else begin
      n_empty = m_empty;
      if (!fifo_en) begin
        n_empty = (tx_level == 0); m_wait = 0; m_cnt = 0;
      end else if (tx_level != 0) begin
        n_empty = 0; m_wait = 0; m_cnt = 0;
      end else if (!m_empty) begin
        if (!m_wait) begin
          if (m_multi) n_empty = 1;
          else begin m_wait = 1; m_cnt = 0; end
        end else if (baud_tick) begin
          if (m_cnt + 1 >= hold_len(wlen, par_en, stop2)) begin
            n_empty = 1; m_wait = 0; m_cnt = 0;
          end else m_cnt = m_cnt + 1;
        end
      end
      if (n_empty && !m_empty) m_multi = 0;
      else if (tx_level >= 2) m_multi = 1;
      n_pend = m_pend;
      if ((n_empty && !m_empty) || (fifo_en != m_fen) ||
          (tx_irq_en && !m_ien && m_empty)) n_pend = 1;
      else if (hold_wr || id_rd) n_pend = 0;
      m_pend = n_pend;
      m_irq  = n_pend && tx_irq_en;
      m_code = m_irq ? 4'h2 : 4'h1;
      m_idle = n_empty && !tsr_busy;
      m_rdy  = (rx_level != 0);
      m_err  = (rx_err_cnt != 0);
      m_empty = n_empty;
      m_fen = fifo_en;
      m_ien = tx_irq_en;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      check("R4 model tx_empty", tx_empty, m_empty);
      check("R10 model tx_idle", tx_idle, m_idle);
      check("R6 model irq", irq, m_irq);
      check("R6 model irq_code", irq_code, m_code);
      check("R11 model rx_ready", rx_ready, m_rdy);
      check("R11 model rx_error", rx_error, m_err);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1: reset values, before and after release
    check("R1 tx_empty in reset", tx_empty, 1);
    check("R1 irq_code in reset", irq_code, 1);
    rst = 1'b0;
    step();
    check("R1 tx_empty", tx_empty, 1);
    check("R1 tx_idle", tx_idle, 1);
    check("R1 irq", irq, 0);
    check("R1 irq_code", irq_code, 4'h1);
    check("R1 rx_ready", rx_ready, 0);
    check("R1 rx_error", rx_error, 0);

    // R2 / R4: one byte, 8N1 gives 144 ticks
    tx_level = 1; hold_wr = 1; step(); hold_wr = 0;
    check("R2 tx_empty drops", tx_empty, 0);
    step(); step();
    tx_level = 0;
    repeat (144) step();
    check("R4 still held at tick 143", tx_empty, 0);
    step();
    check("R4 empty after 144 ticks", tx_empty, 1);
    check("R6 irq after empty rise", irq, 1);
    check("R6 code 2", irq_code, 4'h2);

    // R7: id_rd clears
    id_rd = 1; step(); id_rd = 0;
    check("R7 id_rd clears irq", irq, 0);
    check("R7 code back to 1", irq_code, 4'h1);

    // R3: two bytes together gives an immediate empty
    tx_level = 1; step(); tx_level = 2; step(); tx_level = 1; step();
    tx_level = 0; step();
    check("R3 immediate empty", tx_empty, 1);
    check("R3 irq", irq, 1);

    // R7: hold_wr clears
    hold_wr = 1; step(); hold_wr = 0;
    check("R7 hold_wr clears irq", irq, 0);

    // R4: 5 data bits, parity, two stop bits gives 128 ticks; history cleared
    wlen = 2'd0; par_en = 1; stop2 = 1;
    tx_level = 1; step(); tx_level = 0;
    repeat (128) step();
    check("R4 held at 127 ticks (5E2)", tx_empty, 0);
    step();
    check("R4 empty after 128 ticks (5E2)", tx_empty, 1);

    // R8: fifo_en toggle
    id_rd = 1; step(); id_rd = 0;
    check("R7 cleared before toggle", irq, 0);
    fifo_en = 0; step();
    check("R8 irq after fifo_en change", irq, 1);

    // R5: non-FIFO mode, no hold
    id_rd = 1; step(); id_rd = 0;
    tx_level = 1; step();
    check("R5 empty drops", tx_empty, 0);
    tx_level = 0; step();
    check("R5 empty at once", tx_empty, 1);

    // R9 / R12
    tx_irq_en = 0; step();
    check("R12 masked irq", irq, 0);
    id_rd = 1; step(); id_rd = 0;
    tx_irq_en = 1; step();
    check("R9 enable while empty", irq, 1);
    fifo_en = 1; step();
    id_rd = 1; step(); id_rd = 0;

    // R12 / R11: polled mode
    tx_irq_en = 0;
    tx_level = 2; step(); tx_level = 0; step();
    check("R12 status updates when polled", tx_empty, 1);
    check("R12 irq stays low", irq, 0);
    rx_level = 3; step();
    check("R11 rx_ready set", rx_ready, 1);
    check("R11 rx_error clear", rx_error, 0);
    rx_level = 0; rx_err_cnt = 1; step();
    check("R11 rx_ready clear", rx_ready, 0);
    check("R11 rx_error set", rx_error, 1);
    rx_err_cnt = 0;

    // R10
    tsr_busy = 1; step();
    check("R10 busy shift register", tx_idle, 0);
    check("R10 empty kept", tx_empty, 1);
    tsr_busy = 0; step();
    check("R10 idle", tx_idle, 1);

    // Random bursts against the reference model
    tx_irq_en = 1;
    wlen = 2'($urandom % 4); par_en = 1'($urandom % 2); stop2 = 1'($urandom % 2);
    for (int b = 0; b < 60; b++) begin
      int nbytes = int'($urandom % 3) + 1;
      int gap = int'($urandom % 450);
      for (int k = 0; k < nbytes; k++) begin
        hold_wr = 1; tx_level = tx_level + 1;
        baud_tick = 1'($urandom % 2); tsr_busy = 1;
        step();
        hold_wr = 0;
      end
      while (tx_level != 0) begin
        if ($urandom % 3 == 0) tx_level = tx_level - 1;
        baud_tick = 1'($urandom % 2);
        id_rd = ($urandom % 20 == 0);
        step();
      end
      id_rd = 0;
      for (int g = 0; g < gap; g++) begin
        baud_tick = ($urandom % 4 != 0);
        tsr_busy = ($urandom % 8 == 0);
        id_rd = ($urandom % 60 == 0);
        rx_level = 5'($urandom % 17);
        rx_err_cnt = ($urandom % 5 == 0) ? 5'd1 : 5'd0;
        if ($urandom % 150 == 0) tx_irq_en = ~tx_irq_en;
        if ($urandom % 300 == 0) fifo_en = ~fifo_en;
        step();
      end
      id_rd = 0;
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule